// File: doc/BRIEF.md
# Amplifier Diagnostic Latch and Pin Router

This block gathers fault and clip indications from four amplifier channels together with global supply and temperature flags. Every indication enters as an asynchronous comparator output and passes through a synchronizer. From there it goes two ways. It feeds a sticky status latch that a controller reads over the control bus. It also feeds a live OR network that drives two active-low open-drain diagnostic pins.

The main diagnostic pin always reports a pending power-on reset and both battery-range faults. Configuration bits add the temperature warning, load faults and clip onto that pin. Each channel's clip indication can instead be steered to the standby pin, which then acts as a second clip indicator. A status latch keeps its value until it is read. The pins follow the synchronized conditions and release as soon as those conditions go away.

Each channel also has an output-offset latch with its own rule. A read of the channel's status byte sets it. The differential output passing through its small window clears it. A controller that reads the bit twice, some time apart, therefore learns whether the output has swung through zero in between.

Top module: `diag_status_router`

## Requirements
- R1: Every asynchronous input passes through a two-flop synchronizer. A change applied between clock edges reaches the pins after exactly the second following rising edge. It reaches the status latches one edge later.
- R2: Channel status byte k (index 0..3) holds the short/load fault in bit 0 and clip in bit 1. The global byte (index 4) holds temperature warning in bit 0, low battery in bit 1 and high battery in bit 2. Each of these bits is set while its synchronized condition is high. It stays set after the condition is removed.
- R3: With rd_strobe high, rd_data shows byte rd_idx combinationally in the same cycle. At that edge the bits of R2 in that byte are cleared, unless their condition is still active, because setting wins over clearing. Other bytes are not affected.
- R4: The main pin (diag_pull_o=1 means driven low) is pulled whenever the power-on-reset flag is set, or low battery or high battery is active. No configuration bit can remove these sources.
- R5: Configuration byte 1 bit 4 = 0 puts any channel's short fault on the main pin. Bit 5 = 0 puts the temperature warning on the main pin. Bit 6 = 0 puts the clip of channels routed to the main pin on that pin. A disabled source still sets its status latch.
- R6: The clip routing bits sit in configuration byte 0: channel 0 in bit 5, channel 2 in bit 6, channel 1 in bit 3 and channel 3 in bit 4. A value of 0 routes the clip to the main pin and 1 to the standby pin. The standby pin (stby_pull_o) is pulled only when configuration byte 1 bit 7 = 1 and a channel routed to it is clipping.
- R7: Both pins follow the synchronized conditions only. They release two edges after the last active condition goes away, whatever the status latches hold.
- R8: The power-on-reset flag is global byte bit 7. It is set by reset and by the synchronized power-fail input, and a status read does not clear it. Writing configuration byte 0 with bit 0 = 1 clears it at that edge, unless power-fail is active.
- R9: While the synchronized power-fail input is high, both configuration bytes return to zero and configuration writes have no effect.
- R10: Channel byte k bit 2 is the offset latch. A read of byte k sets it from the next cycle. The synchronized in-window input of channel k clears it, and clearing wins over the read. Reset leaves it 0, and nothing sets it again except another read.
- R11: A read with rd_idx 5 to 7 returns 0 and clears nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| power_fail_a | input | 1 | Async supply-drop indication |
| batt_low_a | input | 1 | Async low battery flag |
| batt_high_a | input | 1 | Async high battery flag |
| temp_warn_a | input | 1 | Async temperature pre-warning |
| ch_short_a | input | 4 | Async per-channel load/short fault |
| ch_clip_a | input | 4 | Async per-channel clip indication |
| ch_inwin_a | input | 4 | Async per-channel output inside offset window |
| cfg_we | input | 1 | Configuration byte write strobe |
| cfg_idx | input | 1 | Configuration byte index (0 or 1) |
| cfg_wdata | input | 8 | Configuration byte value |
| rd_strobe | input | 1 | Status read strobe (clears the byte read) |
| rd_idx | input | 3 | Status byte index |
| rd_data | output | 8 | Status byte being read |
| diag_pull_o | output | 1 | Main diagnostic pin pull-low enable |
| stby_pull_o | output | 1 | Standby pin pull-low enable |

## Verification
The bench builds the block with its defaults: four channels and a synchronizer depth of two. At that depth the exact-latency checks of R1 and R7 apply, and every routing bit of R6 has a channel of its own. Random stimulus mixes reads of all eight indices, which covers the out-of-range reads of R11. It also mixes configuration writes and rare power-fail pulses, so that a pending read, a write and a power-fail can fall in the same cycle. That exposes the priorities between setting and clearing in R3, R8, R9 and R10.

// File: rtl/diag_pkg.sv
// Shared constants for the diagnostic latch and pin router.
// Assumes a fixed four-channel byte layout; the field positions below are
// decoded by the controller and must not move.
package diag_pkg;
    localparam int CH_COUNT   = 4;
    localparam int BYTE_W     = 8;
    localparam int IDX_W      = 3;
    localparam int GLOBAL_IDX = CH_COUNT;
    localparam int GLOB_W     = 3;

    // Bit positions in configuration byte 0
    localparam int C0_START   = 0;
    localparam int C0_RT_CH0  = 5;
    localparam int C0_RT_CH1  = 3;
    localparam int C0_RT_CH2  = 6;
    localparam int C0_RT_CH3  = 4;
    // Bit positions in configuration byte 1
    localparam int C1_LOAD_OFF = 4;
    localparam int C1_TEMP_OFF = 5;
    localparam int C1_CLIP_OFF = 6;
    localparam int C1_STBY_EN  = 7;
    // Indices into the stored enable vector
    localparam int EN_LOAD_OFF = 0;
    localparam int EN_TEMP_OFF = 1;
    localparam int EN_CLIP_OFF = 2;
    localparam int EN_STBY_EN  = 3;
    // Global byte fields
    localparam int G_POR_BIT  = 7;

    // Extract per-channel clip routing from configuration byte 0
    function automatic logic [CH_COUNT-1:0] route_of(input logic [BYTE_W-1:0] b);
        return {b[C0_RT_CH3], b[C0_RT_CH2], b[C0_RT_CH1], b[C0_RT_CH0]};
    endfunction

    // Extract pin enables from configuration byte 1
    function automatic logic [3:0] enables_of(input logic [BYTE_W-1:0] b);
        return {b[C1_STBY_EN], b[C1_CLIP_OFF], b[C1_TEMP_OFF], b[C1_LOAD_OFF]};
    endfunction
endpackage

// File: rtl/diag_sync_bank.sv
// Multi-stage synchronizer bank for independent single-bit async inputs.
// Assumes every bit is a level that may be sampled independently; no bus
// coherency is implied between bits.
module diag_sync_bank #(
    parameter int WIDTH  = 16,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);
    logic [WIDTH-1:0] stage_q [STAGES];

    // Shift each input through the chain of stages
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < STAGES; s++) stage_q[s] <= '0;
        end else begin
            stage_q[0] <= async_i;
            for (int s = 1; s < STAGES; s++) stage_q[s] <= stage_q[s-1];
        end
    end

    assign sync_o = stage_q[STAGES-1];
endmodule

// File: rtl/diag_cfg_regs.sv
// Configuration storage and power-on-reset flag.
// Assumes power-fail is already synchronized; it forces the stored bits
// to zero and keeps the flag set, with priority over writes.
module diag_cfg_regs
    import diag_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 pfail_s,
    input  logic                 cfg_we,
    input  logic                 cfg_idx,
    input  logic [BYTE_W-1:0]    cfg_wdata,
    output logic [CH_COUNT-1:0]  route_q,
    output logic [3:0]           en_q,
    output logic                 por_q
);
    logic start_wr;
    logic unused_cfg_bits;

    assign start_wr        = cfg_we && !cfg_idx && cfg_wdata[C0_START];
    assign unused_cfg_bits = ^{cfg_wdata[2:1]};

    // Hold clip routing and pin enables, cleared by power failure
    always_ff @(posedge clk) begin
        if (!rst_n || pfail_s) begin
            route_q <= '0;
            en_q    <= '0;
        end else if (cfg_we) begin
            if (!cfg_idx) route_q <= route_of(cfg_wdata);
            else          en_q    <= enables_of(cfg_wdata);
        end
    end

    // Power-on-reset flag: set by reset/power-fail, cleared by start write
    always_ff @(posedge clk) begin
        if (!rst_n || pfail_s) por_q <= 1'b1;
        else if (start_wr)     por_q <= 1'b0;
    end
endmodule

// File: rtl/diag_latch_bank.sv
// Sticky status latches, offset latches and the status read multiplexer.
// Assumes synchronized conditions; a read clears the byte it selects while
// an active condition re-sets its bit in the same edge.
module diag_latch_bank
    import diag_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [CH_COUNT-1:0]  short_s,
    input  logic [CH_COUNT-1:0]  clip_s,
    input  logic [CH_COUNT-1:0]  inwin_s,
    input  logic [GLOB_W-1:0]    glob_s,
    input  logic                 por_q,
    input  logic                 rd_strobe,
    input  logic [IDX_W-1:0]     rd_idx,
    output logic [BYTE_W-1:0]    rd_data,
    output logic [CH_COUNT-1:0]  short_q,
    output logic [CH_COUNT-1:0]  clip_q,
    output logic [CH_COUNT-1:0]  off_q,
    output logic [GLOB_W-1:0]    glob_q
);
    logic glob_clr;

    assign glob_clr = rd_strobe && (rd_idx == IDX_W'(GLOBAL_IDX));

    for (genvar k = 0; k < CH_COUNT; k++) begin : g_ch
        logic ch_clr;
        assign ch_clr = rd_strobe && (rd_idx == IDX_W'(k));

        // Sticky fault and clip latches of one channel
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                short_q[k] <= 1'b0;
                clip_q[k]  <= 1'b0;
            end else begin
                short_q[k] <= (short_q[k] & ~ch_clr) | short_s[k];
                clip_q[k]  <= (clip_q[k]  & ~ch_clr) | clip_s[k];
            end
        end

        // Offset latch: armed by a read, cleared by a window crossing
        always_ff @(posedge clk) begin
            if (!rst_n)          off_q[k] <= 1'b0;
            else if (inwin_s[k]) off_q[k] <= 1'b0;
            else if (ch_clr)     off_q[k] <= 1'b1;
        end
    end

    // Sticky global latches
    always_ff @(posedge clk) begin
        if (!rst_n) glob_q <= '0;
        else        glob_q <= (glob_q & ~{GLOB_W{glob_clr}}) | glob_s;
    end

    // Select the status byte addressed by the read
    always_comb begin
        rd_data = '0;
        if (rd_idx < IDX_W'(CH_COUNT)) begin
            rd_data[0] = short_q[rd_idx[1:0]];
            rd_data[1] = clip_q[rd_idx[1:0]];
            rd_data[2] = off_q[rd_idx[1:0]];
        end else if (rd_idx == IDX_W'(GLOBAL_IDX)) begin
            rd_data[GLOB_W-1:0] = glob_q;
            rd_data[G_POR_BIT]  = por_q;
        end
    end
endmodule

// File: rtl/diag_pin_router.sv
// Live OR network for the two active-low diagnostic pins.
// Assumes synchronized live conditions; status latches are not used here,
// so pins release as soon as conditions drop.
module diag_pin_router
    import diag_pkg::*;
(
    input  logic                 por_q,
    input  logic                 temp_s,
    input  logic                 low_s,
    input  logic                 high_s,
    input  logic [CH_COUNT-1:0]  short_s,
    input  logic [CH_COUNT-1:0]  clip_s,
    input  logic [CH_COUNT-1:0]  route_q,
    input  logic [3:0]           en_q,
    output logic                 diag_pull_o,
    output logic                 stby_pull_o
);
    logic fixed_src;
    logic temp_src;
    logic load_src;
    logic clip_main_src;
    logic clip_stby_src;

    // Combine fixed and selectable sources per pin
    always_comb begin
        fixed_src     = por_q | low_s | high_s;
        temp_src      = temp_s & ~en_q[EN_TEMP_OFF];
        load_src      = (|short_s) & ~en_q[EN_LOAD_OFF];
        clip_main_src = (|(clip_s & ~route_q)) & ~en_q[EN_CLIP_OFF];
        clip_stby_src = (|(clip_s & route_q)) & en_q[EN_STBY_EN];
        diag_pull_o   = fixed_src | temp_src | load_src | clip_main_src;
        stby_pull_o   = clip_stby_src;
    end
endmodule

// File: rtl/diag_status_router.sv
// Top of the diagnostic latch and pin router.
// Synchronizes all comparator inputs, stores configuration and the
// power-on-reset flag, keeps sticky status latches and drives two pins.
module diag_status_router
    import diag_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 power_fail_a,
    input  logic                 batt_low_a,
    input  logic                 batt_high_a,
    input  logic                 temp_warn_a,
    input  logic [CH_COUNT-1:0]  ch_short_a,
    input  logic [CH_COUNT-1:0]  ch_clip_a,
    input  logic [CH_COUNT-1:0]  ch_inwin_a,
    input  logic                 cfg_we,
    input  logic                 cfg_idx,
    input  logic [BYTE_W-1:0]    cfg_wdata,
    input  logic                 rd_strobe,
    input  logic [IDX_W-1:0]     rd_idx,
    output logic [BYTE_W-1:0]    rd_data,
    output logic                 diag_pull_o,
    output logic                 stby_pull_o
);
    localparam int RAW_W    = 3*CH_COUNT + 4;
    localparam int OFS_CLIP = CH_COUNT;
    localparam int OFS_WIN  = 2*CH_COUNT;
    localparam int OFS_GLOB = 3*CH_COUNT;

    logic [RAW_W-1:0]    raw_a;
    logic [RAW_W-1:0]    sync_q;
    logic [CH_COUNT-1:0] short_s, clip_s, inwin_s;
    logic [GLOB_W-1:0]   glob_s;
    logic                pfail_s;
    logic [CH_COUNT-1:0] route_q;
    logic [3:0]          en_q;
    logic                por_q;
    logic [CH_COUNT-1:0] short_q, clip_q, off_q;
    logic [GLOB_W-1:0]   glob_q;

    assign raw_a = {power_fail_a, batt_high_a, batt_low_a, temp_warn_a,
                    ch_inwin_a, ch_clip_a, ch_short_a};

    diag_sync_bank #(.WIDTH(RAW_W), .STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (raw_a),
        .sync_o  (sync_q)
    );

    assign short_s = sync_q[CH_COUNT-1:0];
    assign clip_s  = sync_q[OFS_CLIP +: CH_COUNT];
    assign inwin_s = sync_q[OFS_WIN  +: CH_COUNT];
    assign glob_s  = sync_q[OFS_GLOB +: GLOB_W];
    assign pfail_s = sync_q[RAW_W-1];

    diag_cfg_regs u_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .pfail_s   (pfail_s),
        .cfg_we    (cfg_we),
        .cfg_idx   (cfg_idx),
        .cfg_wdata (cfg_wdata),
        .route_q   (route_q),
        .en_q      (en_q),
        .por_q     (por_q)
    );

    diag_latch_bank u_latch (
        .clk       (clk),
        .rst_n     (rst_n),
        .short_s   (short_s),
        .clip_s    (clip_s),
        .inwin_s   (inwin_s),
        .glob_s    (glob_s),
        .por_q     (por_q),
        .rd_strobe (rd_strobe),
        .rd_idx    (rd_idx),
        .rd_data   (rd_data),
        .short_q   (short_q),
        .clip_q    (clip_q),
        .off_q     (off_q),
        .glob_q    (glob_q)
    );

    diag_pin_router u_pins (
        .por_q       (por_q),
        .temp_s      (glob_s[0]),
        .low_s       (glob_s[1]),
        .high_s      (glob_s[2]),
        .short_s     (short_s),
        .clip_s      (clip_s),
        .route_q     (route_q),
        .en_q        (en_q),
        .diag_pull_o (diag_pull_o),
        .stby_pull_o (stby_pull_o)
    );
endmodule

// File: rtl/diag_status_router_chk.sv
// Assertion checker for diag_status_router, attached with bind.
// Assumes the top's internal names for synchronized inputs and latches.
module diag_status_router_chk
    import diag_pkg::*;
(
    input logic                 clk,
    input logic                 rst_n,
    input logic                 rd_strobe,
    input logic [IDX_W-1:0]     rd_idx,
    input logic                 diag_pull_o,
    input logic                 stby_pull_o,
    input logic                 por_q,
    input logic                 pfail_s,
    input logic [GLOB_W-1:0]    glob_s,
    input logic [GLOB_W-1:0]    glob_q,
    input logic [CH_COUNT-1:0]  inwin_s,
    input logic [CH_COUNT-1:0]  off_q,
    input logic [CH_COUNT-1:0]  route_q,
    input logic [3:0]           en_q
);
    a_r8_por_holds_pin: assert property (@(posedge clk) disable iff (!rst_n)
        por_q |-> diag_pull_o);

    a_r2_temp_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (glob_q[0] && !(rd_strobe && rd_idx == IDX_W'(GLOBAL_IDX))) |=> glob_q[0]);

    a_r3_read_clears_temp: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_strobe && rd_idx == IDX_W'(GLOBAL_IDX) && !glob_s[0]) |=> !glob_q[0]);

    a_r10_window_clears: assert property (@(posedge clk) disable iff (!rst_n)
        inwin_s[0] |=> !off_q[0]);

    a_r10_read_arms: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_strobe && rd_idx == '0 && !inwin_s[0]) |=> off_q[0]);

    a_r9_pfail_clears_cfg: assert property (@(posedge clk) disable iff (!rst_n)
        pfail_s |=> (route_q == '0 && en_q == '0 && por_q));

    a_r6_stby_gated: assert property (@(posedge clk) disable iff (!rst_n)
        !en_q[EN_STBY_EN] |-> !stby_pull_o);
endmodule

bind diag_status_router diag_status_router_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .rd_strobe   (rd_strobe),
    .rd_idx      (rd_idx),
    .diag_pull_o (diag_pull_o),
    .stby_pull_o (stby_pull_o),
    .por_q       (por_q),
    .pfail_s     (pfail_s),
    .glob_s      (glob_s),
    .glob_q      (glob_q),
    .inwin_s     (inwin_s),
    .off_q       (off_q),
    .route_q     (route_q),
    .en_q        (en_q)
);

// File: tb/diag_status_router_bench.sv
// Self-checking bench: a requirement-level model predicts rd_data and both
// pins every cycle under directed and seeded random stimulus.
module diag_status_router_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] raw = '0;   // [3:0] short [7:4] clip [11:8] inwin 12 temp 13 low 14 high 15 pfail
    logic        cfg_we = 1'b0, cfg_idx = 1'b0;
    logic [7:0]  cfg_wdata = '0;
    logic        rd_strobe = 1'b0;
    logic [2:0]  rd_idx = '0;
    logic [7:0]  rd_data;
    logic        diag_pull_o, stby_pull_o;

    int n_cmp = 0, n_bad = 0;
    bit compare_on = 1'b0;

    // Model state
    logic [15:0] m_s1, m_s2;
    logic [3:0]  m_sh, m_cl, m_off, m_route, m_en;
    logic [2:0]  m_gl;
    logic        m_por;

    always #4 clk = ~clk;

    diag_status_router u_diag_status_router (
        .clk(clk), .rst_n(rst_n),
        .power_fail_a(raw[15]), .batt_low_a(raw[13]), .batt_high_a(raw[14]),
        .temp_warn_a(raw[12]), .ch_short_a(raw[3:0]), .ch_clip_a(raw[7:4]),
        .ch_inwin_a(raw[11:8]), .cfg_we(cfg_we), .cfg_idx(cfg_idx),
        .cfg_wdata(cfg_wdata), .rd_strobe(rd_strobe), .rd_idx(rd_idx),
        .rd_data(rd_data), .diag_pull_o(diag_pull_o), .stby_pull_o(stby_pull_o)
    );

    function automatic logic [7:0] exp_rd();
        if (rd_idx < 4) return {5'b0, m_off[rd_idx[1:0]], m_cl[rd_idx[1:0]], m_sh[rd_idx[1:0]]};
        if (rd_idx == 4) return {m_por, 4'b0, m_gl};
        return 8'h00;
    endfunction

    function automatic logic exp_diag();
        return m_por | m_s2[13] | m_s2[14] | (m_s2[12] & ~m_en[1])
             | ((|m_s2[3:0]) & ~m_en[0])
             | ((|(m_s2[7:4] & ~m_route)) & ~m_en[2]);
    endfunction

    function automatic logic exp_stby();
        return m_en[3] & (|(m_s2[7:4] & m_route));
    endfunction

    task automatic check(input string tag, input string what, input logic [7:0] act, input logic [7:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %02h expected %02h at %0t", tag, what, act, exp, $time);
        end
    endtask

    // Advance the model by one rising edge using the current inputs
    task automatic model_edge();
        logic [3:0] sh_s, cl_s, in_s;
        logic clr, clrg;
        if (!rst_n) begin
            m_s1 = '0; m_s2 = '0; m_sh = '0; m_cl = '0; m_off = '0;
            m_gl = '0; m_por = 1'b1; m_route = '0; m_en = '0;
            return;
        end
        sh_s = m_s2[3:0]; cl_s = m_s2[7:4]; in_s = m_s2[11:8];
        for (int k = 0; k < 4; k++) begin
            clr = rd_strobe && (rd_idx == 3'(k));
            m_sh[k] = (m_sh[k] & ~clr) | sh_s[k];
            m_cl[k] = (m_cl[k] & ~clr) | cl_s[k];
            m_off[k] = in_s[k] ? 1'b0 : (clr ? 1'b1 : m_off[k]);
        end
        clrg = rd_strobe && (rd_idx == 3'd4);
        m_gl = (m_gl & ~{3{clrg}}) | m_s2[14:12];
        if (m_s2[15]) begin
            m_por = 1'b1; m_route = '0; m_en = '0;
        end else if (cfg_we) begin
            if (!cfg_idx) begin
                m_route = {cfg_wdata[4], cfg_wdata[6], cfg_wdata[3], cfg_wdata[5]};
                if (cfg_wdata[0]) m_por = 1'b0;
            end else begin
                m_en = cfg_wdata[7:4];
            end
        end
        m_s2 = m_s1;
        m_s1 = raw;
    endtask

    // One cycle: compare mid-cycle, take the edge, step the model
    task automatic cyc(input string tag);
        #3;
        if (compare_on) begin
            check(tag, "rd_data", rd_data, exp_rd());
            check(tag, "diag_pull", {7'b0, diag_pull_o}, {7'b0, exp_diag()});
            check(tag, "stby_pull", {7'b0, stby_pull_o}, {7'b0, exp_stby()});
        end
        @(posedge clk);
        model_edge();
        #1;
    endtask

    task automatic idle(); rd_strobe = 0; cfg_we = 0; endtask
    task automatic wr(input logic idx, input logic [7:0] d, input string tag);
        cfg_we = 1; cfg_idx = idx; cfg_wdata = d; cyc(tag); cfg_we = 0;
    endtask
    task automatic rd(input logic [2:0] idx, input string tag);
        rd_strobe = 1; rd_idx = idx; cyc(tag); rd_strobe = 0;
    endtask

    initial begin
        #(8 * 150000);
        n_bad++;
        $display("FAIL watchdog: actual running expected finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        @(posedge clk); model_edge(); #1;
        for (int i = 0; i < 3; i++) cyc("reset");
        rst_n = 1; compare_on = 1;
        // R8: flag set after reset, holds the main pin, survives a read
        rd_idx = 3'd4; cyc("R8 after reset");
        check("R8", "por byte", rd_data, 8'h80);
        rd(3'd4, "R8 read keeps flag");
        cyc("R8 flag still set");
        wr(1'b0, 8'h01, "R8 start write");
        cyc("R8 released");
        check("R8", "pin released", {7'b0, diag_pull_o}, 8'h00);
        // R1: exact synchronizer latency on the main pin
        raw[13] = 1;
        cyc("R1 edge0");
        check("R1", "not yet", {7'b0, diag_pull_o}, 8'h00);
        cyc("R1 edge1");
        check("R1", "after two edges", {7'b0, diag_pull_o}, 8'h01);
        raw[13] = 0; cyc("R7 drop"); cyc("R7 drop2"); cyc("R7 released");
        check("R7", "live release", {7'b0, diag_pull_o}, 8'h00);
        // R4: high battery; R2/R3 global latches
        raw[14] = 1; repeat (4) cyc("R4 high batt");
        raw[14] = 0; repeat (3) cyc("R2 sticky");
        rd_idx = 3'd4; cyc("R2 held");
        check("R2", "high batt latched", rd_data, 8'h06);
        rd(3'd4, "R3 read"); rd(3'd4, "R3 second read");
        // R2/R3: channel short with set-wins-over-clear
        raw[1] = 1; repeat (4) cyc("R2 short ch1");
        rd(3'd1, "R3 read while active"); rd(3'd1, "R3 still set");
        raw[1] = 0; repeat (3) cyc("R3 drop");
        rd(3'd1, "R3 old value"); rd(3'd1, "R3 now clear");
        // R5: disable load and temp on pin, latches still set
        wr(1'b1, 8'h30, "R5 cfg");
        raw[2] = 1; raw[12] = 1; repeat (4) cyc("R5 masked");
        check("R5", "masked pin", {7'b0, diag_pull_o}, 8'h00);
        rd(3'd2, "R5 short latched"); rd(3'd4, "R5 temp latched");
        raw[2] = 0; raw[12] = 0; repeat (3) cyc("R5 settle");
        // R6: route ch2 and ch1 to standby, enable standby clip
        wr(1'b0, 8'h48, "R6 route");
        wr(1'b1, 8'h80, "R6 stby enable");
        raw[6] = 1; repeat (3) cyc("R6 ch2 to stby");
        check("R6", "stby pulled", {7'b0, stby_pull_o}, 8'h01);
        raw[6] = 0; raw[4] = 1; repeat (3) cyc("R6 ch0 to main");
        wr(1'b1, 8'hC0, "R5 clip off main");
        repeat (2) cyc("R5 clip off");
        raw[4] = 0; repeat (3) cyc("R6 settle");
        // R10: offset latch armed by read, cleared by window
        rd(3'd0, "R10 arm"); rd_idx = 3'd0; cyc("R10 armed");
        check("R10", "offset set", rd_data & 8'h04, 8'h04);
        raw[8] = 1; rd(3'd0, "R10 read and window"); repeat (3) cyc("R10 window");
        raw[8] = 0; repeat (3) cyc("R10 stays clear");
        rd_idx = 3'd0; cyc("R10 not re-set");
        // R11: out-of-range reads
        raw[5] = 1; repeat (3) cyc("R11 latch"); raw[5] = 0; repeat (3) cyc("R11 settle");
        rd(3'd6, "R11 idx6"); rd(3'd5, "R11 idx5"); rd_idx = 3'd1; cyc("R11 kept");
        // R9: power fail resets configuration and sets the flag
        raw[15] = 1; repeat (3) cyc("R9 pfail");
        wr(1'b1, 8'hF0, "R9 write ignored");
        raw[15] = 0; repeat (3) cyc("R9 settle");
        wr(1'b0, 8'h01, "R8 restart");
        // Random phase over all requirements
        for (int n = 0; n < 4000; n++) begin
            for (int b = 0; b < 15; b++) if ($urandom % 8 == 0) raw[b] = ~raw[b];
            raw[15] = ($urandom % 97 == 0);
            rd_strobe = ($urandom % 4 == 0);
            rd_idx = 3'($urandom % 8);
            cfg_we = ($urandom % 12 == 0);
            cfg_idx = 1'($urandom % 2);
            cfg_wdata = 8'($urandom);
            cyc("RAND R2 R3 R5 R6 R7 R8 R9 R10 R11");
        end
        idle();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule